// File: doc/BRIEF.md
# Burst SRAM Access Controller

This block is the synchronous front end of a single-port word memory. On every rising clock edge it samples two address strobes, three chip enables and a set of write controls, and from them it decides whether a new access starts, an open access continues, or the part is deselected. A processor-side strobe captures an address and resolves any write one edge later. A controller-side strobe captures an address and commits a write on the same edge. Reads return data through a registered output stage one clock after the address is taken.

The word is split into byte lanes. Each write either stores the whole word (global write) or only the lanes picked by the per-lane selects. A small burst counter steps through the two low address bits while an access stays open, in either linear or interleaved order. The shared data bus is brought out as separate input, output and drive-enable signals, and the pad ring combines them into a tri-state pin.

Top module: `bsram_ctrl`

## Requirements
- R1: After synchronous reset, dq_oe is 0 and dq_o is 0.
- R2: The chip is selected when ce1_n=0, ce2=1 and ce3_n=0. On a rising edge with the part selected and pstrb_n=0, a processor access starts at addr_i. With oe_n=0, the word stored there appears on dq_o with dq_oe=1 after that edge.
- R3: On the starting edge of a processor access, the write controls are ignored. If the following edge deselects the part, memory is unchanged.
- R4: On the edge after a processor start, the strobes both high, adv_n=1 and gwr_n=0 together store dq_i into all four lanes at the captured address.
- R5: In a byte write (gwr_n=1, bwe_n=0), lane i (dq bits 8i+7..8i) is written only when bsel_n[i]=0. The other lanes keep their contents.
- R6: A controller write (cstrb_n=0, pstrb_n=1, part selected, with a write combination) stores dq_i at addr_i on that same edge, so a read started on the very next edge returns the new word.
- R7: When both strobes are low on the same edge, the access is a processor access and the write controls are ignored.
- R8: While gwr_n=0, or while bwe_n=0 with any bsel_n bit low, dq_oe is 0 whatever oe_n is.
- R9: While oe_n=1, dq_oe is 0.
- R10: An edge where the part is not selected and either strobe is low deselects the part: dq_oe is 0 after that edge, no write takes place, and later edges with both strobes high perform no access.
- R11: With burst_lin=1, each edge with both strobes high and adv_n=0 advances an open access. The low two address bits follow (start+k) mod 4 for k=1,2,3,0.
- R12: With burst_lin=0, the advance order is start XOR k.
- R13: Processor reads on consecutive edges each return their own word one clock later, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| burst_lin | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| addr_i | input | AW | Word address |
| pstrb_n | input | 1 | Processor-side address strobe, active low |
| cstrb_n | input | 1 | Controller-side address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_i | input | 32 | Write data from the bus |
| dq_o | output | 32 | Registered read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A registered read result can still be waiting to drive the bus in the same cycle that a write combination appears on the controls. In that cycle the output enable and the write detection meet. The bench provokes this by completing a read with oe_n low and then lowering gwr_n, and later bwe_n with one lane select, before the next edge. It judges the case by dq_oe dropping at once. A second collision is both strobes low on one edge. There the bench asks for a write of a marker word and then reads the old contents back, which shows that the processor strobe won and the write was dropped.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_START_RD,
        OP_START_WR,
        OP_CONT_RD,
        OP_CONT_WR
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] mask;
        logic             load;
        logic             adv;
    } cmd_t;

    // lanes to store for a given set of write controls (active low pins)
    function automatic logic [LANES-1:0] lane_mask(
        input logic             gwr_n,
        input logic             bwe_n,
        input logic [LANES-1:0] bsel_n
    );
        if (!gwr_n)
            return {LANES{1'b1}};
        else if (!bwe_n)
            return ~bsel_n;
        else
            return '0;
    endfunction

    // low two address bits at burst offset k
    function automatic logic [1:0] burst_lo(
        input logic [1:0] start,
        input logic [1:0] k,
        input logic       lin
    );
        return lin ? (start + k) : (start ^ k);
    endfunction

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
(
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             adv_n,
    input  logic             active,
    output cmd_t             cmd,
    output logic             wr_det
);

    logic             sel;
    logic             p_start;
    logic             c_start;
    logic             desel;
    logic             cont;
    logic [LANES-1:0] mask;

    always_comb begin
        sel     = !ce1_n && ce2 && !ce3_n;
        mask    = lane_mask(gwr_n, bwe_n, bsel_n);
        wr_det  = |mask;
        p_start = sel && !pstrb_n;
        c_start = sel && pstrb_n && !cstrb_n;
        desel   = !sel && (!pstrb_n || !cstrb_n);
        cont    = pstrb_n && cstrb_n && active;

        cmd      = '0;
        cmd.op   = OP_IDLE;
        cmd.mask = mask;
        if (p_start) begin
            cmd.op   = OP_START_RD;
            cmd.load = 1'b1;
            cmd.mask = '0;
        end else if (c_start) begin
            cmd.op   = wr_det ? OP_START_WR : OP_START_RD;
            cmd.load = 1'b1;
        end else if (desel) begin
            cmd.op   = OP_DESEL;
            cmd.mask = '0;
        end else if (cont) begin
            cmd.op  = wr_det ? OP_CONT_WR : OP_CONT_RD;
            cmd.adv = !adv_n;
        end else begin
            cmd.mask = '0;
        end
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_lin,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    import bsram_pkg::*;

    logic [AW-1:0] base_q;
    logic [1:0]    k_q;
    logic [1:0]    k_nxt;

    assign k_nxt = k_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            k_q    <= '0;
        end else if (load) begin
            base_q <= addr_i;
            k_q    <= '0;
        end else if (adv) begin
            k_q    <= k_nxt;
        end
    end

    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], k_q,   burst_lin)};
        nxt_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], k_nxt, burst_lin)};
    end

endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  mask,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] ram [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g])
                ram[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = ram[addr];
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_lin,
    input  logic [AW-1:0]     addr_i,
    input  logic              pstrb_n,
    input  logic              cstrb_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    cmd_t              cmd;
    logic              wr_det;
    logic              active_q;
    logic              rd_valid_q;
    logic [WORD_W-1:0] rd_q;
    logic [AW-1:0]     cur_addr;
    logic [AW-1:0]     nxt_addr;
    logic [AW-1:0]     acc_addr;
    logic [WORD_W-1:0] rdata;
    logic              we;

    bsram_decode i_decode (
        .pstrb_n (pstrb_n),
        .cstrb_n (cstrb_n),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .gwr_n   (gwr_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .adv_n   (adv_n),
        .active  (active_q),
        .cmd     (cmd),
        .wr_det  (wr_det)
    );

    bsram_burst #(.AW(AW)) i_burst (
        .clk       (clk),
        .rst       (rst),
        .burst_lin (burst_lin),
        .load      (cmd.load),
        .adv       (cmd.adv),
        .addr_i    (addr_i),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    always_comb begin
        if (cmd.load)
            acc_addr = addr_i;
        else if (cmd.adv)
            acc_addr = nxt_addr;
        else
            acc_addr = cur_addr;
        we = (cmd.op == OP_START_WR) || (cmd.op == OP_CONT_WR);
    end

    bsram_lanes #(.AW(AW)) i_lanes (
        .clk   (clk),
        .we    (we),
        .mask  (cmd.mask),
        .addr  (acc_addr),
        .wdata (dq_i),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_q       <= '0;
        end else begin
            unique case (cmd.op)
                OP_DESEL: begin
                    active_q   <= 1'b0;
                    rd_valid_q <= 1'b0;
                end
                OP_START_RD, OP_CONT_RD: begin
                    active_q   <= 1'b1;
                    rd_valid_q <= 1'b1;
                    rd_q       <= rdata;
                end
                OP_START_WR, OP_CONT_WR: begin
                    active_q   <= 1'b1;
                    rd_valid_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign dq_o  = rd_q;
    assign dq_oe = !oe_n && rd_valid_q && !wr_det;

endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pstrb_n,
    input logic       cstrb_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       ce3_n,
    input logic       gwr_n,
    input logic       bwe_n,
    input logic [3:0] bsel_n,
    input logic       oe_n,
    input logic       dq_oe
);
    logic sel_c, wrc_c;
    assign sel_c = !ce1_n && ce2 && !ce3_n;
    assign wrc_c = !gwr_n || (!bwe_n && (bsel_n != 4'hF));

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !dq_oe);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_c && !pstrb_n) |=> (oe_n || wrc_c || dq_oe));

    assert_cwrite_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_c && pstrb_n && !cstrb_n && wrc_c) |=> (!dq_oe || (pstrb_n == 1'b0)));

    assert_write_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        wrc_c |-> !dq_oe);

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    assert_desel_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        (!sel_c && (!pstrb_n || !cstrb_n)) |=> !dq_oe);

endmodule

bind bsram_ctrl bsram_ctrl_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .pstrb_n (pstrb_n),
    .cstrb_n (cstrb_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .gwr_n   (gwr_n),
    .bwe_n   (bwe_n),
    .bsel_n  (bsel_n),
    .oe_n    (oe_n),
    .dq_oe   (dq_oe)
);

// File: tb/test_bsram_ctrl.sv
module test_bsram_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          burst_lin;
    logic [AW-1:0] addr_i;
    logic          pstrb_n, cstrb_n, ce1_n, ce2, ce3_n;
    logic          gwr_n, bwe_n, adv_n, oe_n;
    logic [3:0]    bsel_n;
    logic [31:0]   dq_i, dq_o;
    logic          dq_oe;

    int total = 0;
    int bad   = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    bsram_ctrl #(.AW(AW)) i_bsram_ctrl (.*);

    // row: kind[75:74] addr[73:68] bsel_n[67:64] data[63:32] exp[31:0]
    // kind 0 = controller byte write, 1 = processor read, 2 = processor global write
    localparam logic [75:0] VEC [8] = '{
        {2'd0, 6'd1, 4'b0000, 32'h1122_3344, 32'h0},           // R6 full via lanes
        {2'd2, 6'd2, 4'b1111, 32'hA5A5_0F0F, 32'h0},           // R4
        {2'd1, 6'd1, 4'b1111, 32'h0,         32'h1122_3344},   // R2
        {2'd1, 6'd2, 4'b1111, 32'h0,         32'hA5A5_0F0F},   // R4 readback
        {2'd0, 6'd1, 4'b1100, 32'hFFFF_EEEE, 32'h0},           // R5 lanes 0,1
        {2'd1, 6'd1, 4'b1111, 32'h0,         32'h1122_EEEE},   // R5 readback
        {2'd2, 6'd3, 4'b1111, 32'h0BAD_F00D, 32'h0},           // R4
        {2'd1, 6'd3, 4'b1111, 32'h0,         32'h0BAD_F00D}    // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pstrb_n = 1; cstrb_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gwr_n = 1; bwe_n = 1; bsel_n = 4'hF; adv_n = 1; oe_n = 0;
    endtask

    task automatic cwrite(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic gw, input logic [3:0] bs);
        cstrb_n = 0; addr_i = a; dq_i = d; gwr_n = gw; bwe_n = 0; bsel_n = bs;
        tick();
        idle();
    endtask

    task automatic pwrite(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic gw, input logic [3:0] bs);
        pstrb_n = 0; addr_i = a; gwr_n = gw; bwe_n = 0; bsel_n = bs;
        dq_i = 32'hDEAD_BEEF;
        tick();
        pstrb_n = 1; dq_i = d;
        tick();
        idle();
    endtask

    task automatic pread(input logic [AW-1:0] a, output logic [31:0] d);
        pstrb_n = 0; addr_i = a;
        tick();
        d = dq_o;
        idle();
    endtask

    function automatic logic [1:0] lo_of(input logic [1:0] s, input logic [1:0] k,
                                         input logic lin);
        return lin ? 2'((s + k) & 2'd3) : (s ^ k);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        burst_lin = 1; addr_i = 0; dq_i = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 dq_oe", {31'b0, dq_oe}, 32'h0);
        check("R1 dq_o", dq_o, 32'h0);
        rst = 0;

        for (int i = 0; i < 8; i++) begin
            logic [75:0] v;
            v = VEC[i];
            case (v[75:74])
                2'd0: cwrite(v[73:68], v[63:32], 1'b1, v[67:64]);
                2'd2: pwrite(v[73:68], v[63:32], 1'b0, 4'hF);
                default: begin
                    pread(v[73:68], got);
                    check("R2 table read", got, v[31:0]);
                    check("R2 table drive", {31'b0, dq_oe}, 32'h1);
                end
            endcase
        end

        // R5 processor byte write, lanes 0 and 2
        pwrite(6'd3, 32'h1111_2222, 1'b1, 4'b1010);
        pread(6'd3, got);
        check("R5 byte mask", got, 32'h0B11_F022);

        // R6 same-edge completion, read started on the next edge
        cwrite(6'd4, 32'hCAFE_0004, 1'b0, 4'hF);
        pread(6'd4, got);
        check("R6 same edge", got, 32'hCAFE_0004);

        // R13 back-to-back reads
        pread(6'd2, got);
        check("R13 first", got, 32'hA5A5_0F0F);
        pread(6'd4, got);
        check("R13 second", got, 32'hCAFE_0004);

        // R8 write detect overrides output enable
        check("R8 pre", {31'b0, dq_oe}, 32'h1);
        gwr_n = 0; #1;
        check("R8 global", {31'b0, dq_oe}, 32'h0);
        gwr_n = 1; bwe_n = 0; bsel_n = 4'b1101; #1;
        check("R8 byte", {31'b0, dq_oe}, 32'h0);
        idle(); #1;
        // R9 output enable off
        oe_n = 1; #1;
        check("R9 oe high", {31'b0, dq_oe}, 32'h0);
        idle();

        // R3 write controls ignored on processor start, then deselect
        pstrb_n = 0; addr_i = 6'd4; gwr_n = 0; dq_i = 32'h5555_5555;
        tick();
        ce1_n = 1; pstrb_n = 0; gwr_n = 1;
        tick();
        idle();
        pread(6'd4, got);
        check("R3 ignored", got, 32'hCAFE_0004);

        // R7 both strobes low: processor priority, write dropped
        pstrb_n = 0; cstrb_n = 0; addr_i = 6'd4; gwr_n = 0; dq_i = 32'h7777_7777;
        tick();
        ce1_n = 1; pstrb_n = 0; cstrb_n = 1; gwr_n = 1;
        tick();
        idle();
        pread(6'd4, got);
        check("R7 priority", got, 32'hCAFE_0004);

        // R10 deselect
        check("R10 pre", {31'b0, dq_oe}, 32'h1);
        ce3_n = 1; cstrb_n = 0;
        tick();
        idle();
        check("R10 hiz", {31'b0, dq_oe}, 32'h0);
        tick();
        check("R10 no access", {31'b0, dq_oe}, 32'h0);
        ce2 = 0; cstrb_n = 0; addr_i = 6'd4; dq_i = 32'h9999_9999; gwr_n = 0;
        tick();
        idle();
        pread(6'd4, got);
        check("R10 no write", got, 32'hCAFE_0004);

        // preload words 8..11
        for (int j = 0; j < 4; j++)
            cwrite(6'(8 + j), 32'hB000_0000 + 32'(j), 1'b0, 4'hF);

        // R11 linear and R12 interleaved bursts starting at offset 1
        for (int m = 0; m < 2; m++) begin
            burst_lin = (m == 0);
            pread(6'd9, got);
            check(m == 0 ? "R11 start" : "R12 start", got, 32'hB000_0001);
            for (int k = 1; k < 4; k++) begin
                adv_n = 0;
                tick();
                adv_n = 1;
                check(m == 0 ? "R11 step" : "R12 step", dq_o,
                      32'hB000_0000 + 32'(lo_of(2'd1, 2'(k), burst_lin)));
            end
            adv_n = 0;
            tick();
            idle();
            check(m == 0 ? "R11 wrap" : "R12 wrap", dq_o, 32'hB000_0001);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule